// File: doc/BRIEF.md
# Writable Opcode Dispatch Mapper

This block turns a one-byte machine opcode into the entry address of the microroutine that carries out that instruction. The mapping is held in writable tables rather than a fixed decoder, so the instruction set can be changed while the machine runs. There are several banks of tables. A bank-select input chooses which bank is active for each lookup, so software can give each context or privilege mode its own instruction set and switch between them on a context switch.

Each bank has two 256-entry tables: a primary table and an extension table. The opcode `0xFF` is reserved as an escape. It produces no dispatch. Instead it arms a flag, and the next valid opcode byte is looked up in the extension table of the bank selected for that byte. This lets the instruction set grow past 256 codes. Every entry stores an even-parity bit beside its address. The bit is checked on every lookup. A bad entry redirects the dispatch to a fixed trap vector and sets a sticky error flag.

The lookup runs in a single cycle, in parallel with the rest of the sequencer's work. The result is registered, so it appears one cycle after the opcode is presented.

Top module: `opcode_dispatch_mapper`

## Requirements
- R1: After synchronous reset, `disp_valid` is 0, `disp_addr` is 0, `parity_err` is 0, and no escape is pending.
- R2: An accepted opcode other than `0xFF`, with no escape pending, is looked up in the primary table of `bank_sel`. On the next clock `disp_valid` is 1 and `disp_addr` holds the stored address bits `[ADDR_W-1:0]` of that entry.
- R3: An accepted opcode `0xFF` with no escape pending gives `disp_valid` = 0 on the next clock and arms the escape. The next accepted opcode is then looked up in the extension table, and that lookup clears the escape.
- R4: During an extension lookup, `0xFF` is an ordinary index into the extension table and does not arm a second escape.
- R5: Each bank has its own primary and extension tables. The bank used for a lookup is the value of `bank_sel` in the cycle that the looked-up byte is accepted, including the byte that follows an escape.
- R6: A table entry has `ADDR_W+1` bits. Bit `ADDR_W` is the parity bit, and the entry is good when that bit equals the XOR of bits `[ADDR_W-1:0]`. A lookup of a bad entry still gives `disp_valid` = 1, but `disp_addr` = `TRAP_VEC` and `parity_err` becomes 1.
- R7: Once set, `parity_err` stays 1 until reset, whatever later lookups return.
- R8: A write (`wr_en`) that happens in the same cycle as `op_valid` is dropped, and the addressed entry keeps its old contents. A write with `op_valid` low stores `wr_entry` at (`wr_bank`, `wr_ext`, `wr_opcode`).
- R9: `disp_valid` is 0 on the clock after any cycle in which `op_valid` is low.
- R10: A pending escape survives any number of cycles with `op_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_bank | input | BANK_W | Bank of the entry to write |
| wr_ext | input | 1 | 1 writes the extension table, 0 writes the primary table |
| wr_opcode | input | 8 | Opcode index of the entry to write |
| wr_entry | input | ADDR_W+1 | Entry data: parity bit at the top, address bits below |
| op_valid | input | 1 | An opcode byte is presented this cycle |
| opcode | input | 8 | Opcode byte |
| bank_sel | input | BANK_W | Active table bank |
| disp_valid | output | 1 | Registered dispatch address is valid |
| disp_addr | output | ADDR_W | Microprogram entry address, or the trap vector |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
The assertions assume that `bank_sel` and `wr_bank` never point past `NUM_BANKS-1`, and that reset is applied before the first opcode. The stimulus only drives bank numbers that exist, and it holds reset over the first clock edges. The escape and sticky-flag properties also assume that software writes every entry before that entry is looked up. To meet this, the bench fills every table of every bank before any lookup. Bad entries are written on purpose, and only to check the trap path.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;

    localparam int OPC_W     = 8;
    localparam int TBL_DEPTH = 1 << OPC_W;
    localparam logic [OPC_W-1:0] ESC_CODE = 8'hFF;

    typedef logic [OPC_W-1:0] opcode_t;

    typedef enum logic {
        LK_PRIMARY = 1'b0,
        LK_EXTEND  = 1'b1
    } lookup_kind_e;

endpackage

// File: rtl/dispatch_table.sv
module dispatch_table
    import dispatch_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ENT_W     = 13,
    parameter int BANK_W    = 2
) (
    input  logic                clk,
    input  logic                wr_go,
    input  logic [BANK_W-1:0]   wr_bank,
    input  lookup_kind_e        wr_kind,
    input  opcode_t             wr_opc,
    input  logic [ENT_W-1:0]    wr_entry,
    input  logic [BANK_W-1:0]   rd_bank,
    input  lookup_kind_e        rd_kind,
    input  opcode_t             rd_opc,
    output logic [ENT_W-1:0]    rd_entry
);

    logic [ENT_W-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [ENT_W-1:0] prim_mem [TBL_DEPTH];
        logic [ENT_W-1:0] ext_mem  [TBL_DEPTH];
        logic             hit;

        assign hit = wr_go && (int'(wr_bank) == b);

        always_ff @(posedge clk) begin
            if (hit && wr_kind == LK_PRIMARY) prim_mem[wr_opc] <= wr_entry;
            if (hit && wr_kind == LK_EXTEND)  ext_mem[wr_opc]  <= wr_entry;
        end

        assign bank_rd[b] = (rd_kind == LK_EXTEND) ? ext_mem[rd_opc] : prim_mem[rd_opc];
    end

    always_comb begin
        rd_entry = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (int'(rd_bank) == b) rd_entry = bank_rd[b];
        end
    end

endmodule

// File: rtl/dispatch_escape.sv
module dispatch_escape
    import dispatch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  opcode_t       opcode,
    output logic          esc_pending,
    output logic          lookup_go,
    output lookup_kind_e  lookup_kind
);

    logic arm;

    assign arm         = op_valid && !esc_pending && (opcode == ESC_CODE);
    assign lookup_go   = op_valid && !arm;
    assign lookup_kind = esc_pending ? LK_EXTEND : LK_PRIMARY;

    always_ff @(posedge clk) begin
        if (rst)           esc_pending <= 1'b0;
        else if (arm)      esc_pending <= 1'b1;
        else if (op_valid) esc_pending <= 1'b0;
    end

    // R3
    esc_arms_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !esc_pending && opcode == ESC_CODE) |=> esc_pending);

    // R4
    no_nested_esc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && esc_pending) |=> !esc_pending);

    // R10
    esc_holds_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(esc_pending));

endmodule

// File: rtl/opcode_dispatch_mapper.sv
module opcode_dispatch_mapper
    import dispatch_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] TRAP_VEC = '1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int ENT_W    = ADDR_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [BANK_W-1:0]  wr_bank,
    input  logic               wr_ext,
    input  logic [7:0]         wr_opcode,
    input  logic [ENT_W-1:0]   wr_entry,
    input  logic               op_valid,
    input  logic [7:0]         opcode,
    input  logic [BANK_W-1:0]  bank_sel,
    output logic               disp_valid,
    output logic [ADDR_W-1:0]  disp_addr,
    output logic               parity_err
);

    typedef struct packed {
        logic              par;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    logic         esc_pending;
    logic         lookup_go;
    lookup_kind_e lookup_kind;
    logic         wr_go;
    entry_t       rd_entry;
    logic         entry_bad;

    assign wr_go = wr_en && !op_valid;

    dispatch_escape u_esc (
        .clk         (clk),
        .rst         (rst),
        .op_valid    (op_valid),
        .opcode      (opcode),
        .esc_pending (esc_pending),
        .lookup_go   (lookup_go),
        .lookup_kind (lookup_kind)
    );

    dispatch_table #(
        .NUM_BANKS (NUM_BANKS),
        .ENT_W     (ENT_W),
        .BANK_W    (BANK_W)
    ) u_tbl (
        .clk      (clk),
        .wr_go    (wr_go),
        .wr_bank  (wr_bank),
        .wr_kind  (lookup_kind_e'(wr_ext)),
        .wr_opc   (wr_opcode),
        .wr_entry (wr_entry),
        .rd_bank  (bank_sel),
        .rd_kind  (lookup_kind),
        .rd_opc   (opcode),
        .rd_entry (rd_entry)
    );

    assign entry_bad = (rd_entry.par != ^rd_entry.addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            disp_valid <= 1'b0;
            disp_addr  <= '0;
            parity_err <= 1'b0;
        end else begin
            disp_valid <= lookup_go;
            if (lookup_go) begin
                disp_addr <= entry_bad ? TRAP_VEC : rd_entry.addr;
                if (entry_bad) parity_err <= 1'b1;
            end
        end
    end

    // R9
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> $past(op_valid));

    // R3
    esc_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !esc_pending && opcode == ESC_CODE) |=> !disp_valid);

    // R7
    perr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        parity_err |=> parity_err);

    // R6
    trap_on_perr_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(parity_err) |-> (disp_valid && disp_addr == TRAP_VEC));

endmodule

// File: tb/sim_opcode_dispatch_mapper.sv
module sim_opcode_dispatch_mapper;

    localparam int NB     = 2;
    localparam int AW     = 12;
    localparam int BW     = 1;
    localparam logic [AW-1:0] TRAP = 12'hFFF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [BW-1:0] wr_bank = '0;
    logic          wr_ext = 1'b0;
    logic [7:0]    wr_opcode = '0;
    logic [AW:0]   wr_entry = '0;
    logic          op_valid = 1'b0;
    logic [7:0]    opcode = '0;
    logic [BW-1:0] bank_sel = '0;
    logic          disp_valid;
    logic [AW-1:0] disp_addr;
    logic          parity_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    opcode_dispatch_mapper #(.NUM_BANKS(NB), .ADDR_W(AW), .TRAP_VEC(TRAP)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_bank(wr_bank), .wr_ext(wr_ext),
        .wr_opcode(wr_opcode), .wr_entry(wr_entry), .op_valid(op_valid),
        .opcode(opcode), .bank_sel(bank_sel), .disp_valid(disp_valid),
        .disp_addr(disp_addr), .parity_err(parity_err)
    );

    function automatic logic [AW-1:0] exp_addr(int b, int e, int o);
        return AW'((o * 37 + b * 611 + e * 1500 + 3) % 4096);
    endfunction

    function automatic logic [AW:0] good_entry(logic [AW-1:0] a);
        return {^a, a};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(int b, int e, int o, logic [AW:0] ent, bit with_op);
        @(negedge clk);
        wr_en = 1'b1; wr_bank = BW'(b); wr_ext = e[0]; wr_opcode = 8'(o); wr_entry = ent;
        op_valid = with_op; opcode = 8'h01; bank_sel = '0;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; op_valid = 1'b0;
    endtask

    // presents one byte; outputs sampled at the following negedge
    task automatic present(int b, int o);
        @(negedge clk);
        op_valid = 1'b1; opcode = 8'(o); bank_sel = BW'(b);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 valid", disp_valid, 0);
        check("R1 addr", disp_addr, 0);
        check("R1 perr", parity_err, 0);

        for (int b = 0; b < NB; b++)
            for (int e = 0; e < 2; e++)
                for (int o = 0; o < 256; o++)
                    do_write(b, e, o, good_entry(exp_addr(b, e, o)), 1'b0);

        // R1 no escape pending after reset: 0x01 goes to primary
        present(0, 8'h01);
        check("R1 no escape", disp_addr, exp_addr(0, 0, 1));

        // R2 R5 primary sweep, both banks
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < 255; o++) begin
                present(b, o);
                check("R2 valid", disp_valid, 1);
                check("R5 addr", disp_addr, exp_addr(b, 0, o));
            end

        // R9 idle gives no dispatch
        idle(1);
        check("R9 idle", disp_valid, 0);

        // R3 R4 extension sweep
        for (int b = 0; b < NB; b++)
            for (int o = 0; o < 256; o++) begin
                present(b, 8'hFF);
                check("R3 silent", disp_valid, 0);
                present(b, o);
                check("R3 ext valid", disp_valid, 1);
                check("R4 ext addr", disp_addr, exp_addr(b, 1, o));
            end

        // R3 escape clears: next byte goes to primary
        present(1, 8'h22);
        check("R3 cleared", disp_addr, exp_addr(1, 0, 8'h22));

        // R4 ext 0xFF does not re-arm
        present(0, 8'hFF);
        present(0, 8'hFF);
        check("R4 ext ff", disp_addr, exp_addr(0, 1, 255));
        present(0, 8'h05);
        check("R4 no rearm", disp_addr, exp_addr(0, 0, 5));

        // R10 R5 escape across idle cycles and a bank change
        present(0, 8'hFF);
        idle(5);
        present(1, 8'h40);
        check("R10 held", disp_valid, 1);
        check("R5 bank after esc", disp_addr, exp_addr(1, 1, 8'h40));

        // R8 write colliding with a lookup is dropped
        do_write(0, 0, 8'h10, good_entry(12'h123), 1'b1);
        present(0, 8'h10);
        check("R8 dropped", disp_addr, exp_addr(0, 0, 8'h10));
        do_write(0, 0, 8'h10, good_entry(12'h123), 1'b0);
        present(0, 8'h10);
        check("R8 stored", disp_addr, 12'h123);

        // R6 bad parity entry traps
        check("R6 clean before", parity_err, 0);
        do_write(1, 0, 8'h20, {~(^exp_addr(1, 0, 8'h20)), exp_addr(1, 0, 8'h20)}, 1'b0);
        present(1, 8'h20);
        check("R6 valid", disp_valid, 1);
        check("R6 trap", disp_addr, TRAP);
        check("R6 perr", parity_err, 1);

        // R7 sticky through good lookups
        present(1, 8'h21);
        check("R7 good addr", disp_addr, exp_addr(1, 0, 8'h21));
        check("R7 sticky", parity_err, 1);
        idle(3);
        check("R7 sticky idle", parity_err, 1);

        // R1 reset clears the flag
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 perr cleared", parity_err, 0);
        check("R1 valid cleared", disp_valid, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule